// File: doc/BRIEF.md
# Egress Link Header Builder

This block produces the outgoing link-layer header for one frame on the egress side of a line card. A request carries the result of the egress table lookup: the link kind, the output port, the link identifier, and the fields that only some kinds use, which are a destination MAC, a VLAN tag control word and a tunnel destination IPv4 address. The same request also carries the next-hop MAC from address resolution and the payload length. The builder merges these with two configured tables and fixed constants. One table gives a source MAC per port. The other gives a tunnel source IPv4 address for each physical interface.

For IPv4 tunnels it builds a complete 20-byte IP header. The total length is computed from the payload length, the identification comes from a wrapping per-packet counter, and the header checksum is computed in line. The finished header leaves as a byte stream, most significant byte first, ahead of the payload. The request side and the byte side are both valid/ready. A request is taken only while no header is in flight, and `out_ready` low freezes the byte stream exactly where it stands.

Top module: `ehb_encap_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The first header byte is valid in the next cycle. `req_ready` stays 0 until the last byte of that header has been taken, and returns to 1 in the cycle after.
- R3: While `out_valid` is 1 and `out_ready` is 0, the following cycle still has `out_valid` 1, and `out_data` and `out_last` are unchanged.
- R4: Kind 0 (direct link) emits 16 bytes: destination MAC from the request, source MAC, EtherType 0x88B5, link identifier.
- R5: Kind 1 (IPv4 tunnel) emits 36 bytes: destination MAC from the request, source MAC, EtherType 0x0800, the 20-byte IP header, link identifier.
- R6: The tunnel IP header has these fixed words and computed fields:
  - word 0 is 0x4500, word 3 is 0x4000, and word 4 is 0x40FD (TTL 64, protocol 0xFD);
  - word 1, the total length, is the payload length + 22, modulo 2^16;
  - words 6-7 hold the source address and words 8-9 hold the request's tunnel destination address.
- R7: Tunnel header word 5 is the bit inverse of the end-around-carry 16-bit sum of the other nine words.
- R8: Tunnel header word 2 takes the identification counter. The counter starts at `IDENT_INIT` after reset and steps by 1 for each tunnel request taken. It wraps from 0xFFFF to 0x0000 and does not move for any other kind.
- R9: The tunnel source address is entry `req_port` of the interface table (bits `[32*i +: 32]`). It is 0.0.0.0 when `req_port` is `NUM_IFS` or more.
- R10: For every kind, bytes 6-11 are entry `req_port` of the port MAC table (bits `[48*p +: 48]`).
- R11: Kind 2 (legacy IPv4) emits 14 bytes: `req_nh_mac`, source MAC, EtherType 0x0800. Kind 4 (multi-access) emits 16 bytes: `req_nh_mac`, source MAC, 0x88B5, link identifier. For both kinds `req_dst_mac` has no effect.
- R12: Kind 3 (VLAN-0 point-to-point) emits 20 bytes: destination MAC, source MAC, 0x8100, `req_tci`, 0x88B5, link identifier.
- R13: Kind codes 5 to 15 produce the kind 0 header.
- R14: `out_last` is 1 on the final byte of each header and on no other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Builder idle, request can be taken |
| req_kind | input | 4 | Link kind code |
| req_port | input | PORT_W | Physical output port |
| req_link_id | input | 16 | Link identifier |
| req_dst_mac | input | 48 | Destination MAC from lookup |
| req_tci | input | 16 | VLAN tag control word |
| req_tun_dst | input | 32 | Tunnel destination IPv4 address |
| req_nh_mac | input | 48 | Resolved next-hop MAC |
| req_pay_len | input | 16 | Bytes following the IP header's link identifier |
| cfg_port_mac | input | NUM_PORTS*48 | Source MAC per port |
| cfg_if_ip | input | NUM_IFS*32 | Tunnel source IPv4 per interface |
| out_valid | output | 1 | Header byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Header byte |
| out_last | output | 1 | Final header byte |

## Verification
The bench starts the identification counter two steps below its wrap point, so a run of tunnel headers crosses 0xFFFF to 0x0000. A counter that saturated or skipped a value would put a wrong identification and checksum into every header after the crossing. A payload length near 2^16 wraps the IP total length, and a port at or above the interface count checks the zero source address; an unguarded table read would fetch an undefined entry. Address-resolved kinds get a request destination MAC that differs from the resolved one, unknown kind codes must fall back to the direct form, and random back-pressure with back-to-back requests shows whether bytes get dropped, duplicated or allowed to change while stalled.

// File: rtl/ehb_pkg.sv
package ehb_pkg;

  localparam int unsigned MAC_W        = 48;
  localparam int unsigned IP_W         = 32;
  localparam int unsigned LID_W        = 16;
  localparam int unsigned TCI_W        = 16;
  localparam int unsigned LEN_W        = 16;
  localparam int unsigned KIND_W       = 4;

  localparam int unsigned ETH_BYTES    = 14;
  localparam int unsigned LID_BYTES    = 2;
  localparam int unsigned IP_HDR_BYTES = 20;
  localparam int unsigned IP_WORDS     = IP_HDR_BYTES / 2;
  localparam int unsigned MAX_HDR_BYTES = ETH_BYTES + IP_HDR_BYTES + LID_BYTES;
  localparam int unsigned HDR_W        = MAX_HDR_BYTES * 8;
  localparam int unsigned CNT_W        = $clog2(MAX_HDR_BYTES + 1);

  localparam logic [15:0] ETYPE_VLAN   = 16'h8100;
  localparam logic [15:0] ETYPE_IPV4   = 16'h0800;

  typedef enum logic [2:0] {
    SHP_DIRECT,
    SHP_TUNNEL,
    SHP_LEGACY,
    SHP_VLAN0,
    SHP_MULTI
  } shape_e;

  function automatic shape_e kind_to_shape(logic [KIND_W-1:0] kind);
    case (kind)
      4'd1:    return SHP_TUNNEL;
      4'd2:    return SHP_LEGACY;
      4'd3:    return SHP_VLAN0;
      4'd4:    return SHP_MULTI;
      default: return SHP_DIRECT;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] shape_bytes(shape_e shp);
    case (shp)
      SHP_TUNNEL: return CNT_W'(ETH_BYTES + IP_HDR_BYTES + LID_BYTES);
      SHP_LEGACY: return CNT_W'(ETH_BYTES);
      SHP_VLAN0:  return CNT_W'(ETH_BYTES + 4 + LID_BYTES);
      default:    return CNT_W'(ETH_BYTES + LID_BYTES);
    endcase
  endfunction

  // 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/ehb_port_table.sv
module ehb_port_table #(
  parameter int unsigned ENTRY_W = 48,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [ENTRIES*ENTRY_W-1:0] table_flat,
  input  logic [IDX_W-1:0]           idx,
  output logic [ENTRY_W-1:0]         entry
);

  logic [ENTRY_W-1:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign ent[g] = table_flat[g*ENTRY_W +: ENTRY_W];
  end

  if (ENTRIES >= (1 << IDX_W)) begin : g_full
    // every index value names an entry
    assign entry = ent[idx];
  end else begin : g_partial
    always_comb begin
      if (int'(idx) < ENTRIES) entry = ent[idx];
      else                     entry = '0;
    end
  end

endmodule

// File: rtl/ehb_ipv4_hdr.sv
module ehb_ipv4_hdr
  import ehb_pkg::*;
#(
  parameter logic [7:0]  TOS        = 8'h00,
  parameter logic [7:0]  TTL        = 8'd64,
  parameter logic [7:0]  PROTO      = 8'hFD,
  parameter logic [15:0] FLAGS_FRAG = 16'h4000
) (
  input  logic [LEN_W-1:0]        total_len,
  input  logic [15:0]             ident,
  input  logic [IP_W-1:0]         src_ip,
  input  logic [IP_W-1:0]         dst_ip,
  output logic [IP_HDR_BYTES*8-1:0] hdr
);

  localparam int unsigned CSUM_WORD = 5;
  localparam logic [7:0]  VER_IHL   = 8'h45;

  logic [15:0] w [IP_WORDS];
  logic [15:0] acc;
  logic [15:0] csum;

  always_comb begin
    w[0] = {VER_IHL, TOS};
    w[1] = total_len;
    w[2] = ident;
    w[3] = FLAGS_FRAG;
    w[4] = {TTL, PROTO};
    w[CSUM_WORD] = 16'h0000;
    w[6] = src_ip[31:16];
    w[7] = src_ip[15:0];
    w[8] = dst_ip[31:16];
    w[9] = dst_ip[15:0];
    acc = 16'h0000;
    for (int i = 0; i < IP_WORDS; i++) acc = oc_add(acc, w[i]);
    csum = ~acc;
    hdr = {w[0], w[1], w[2], w[3], w[4], csum, w[6], w[7], w[8], w[9]};
  end

endmodule

// File: rtl/ehb_ident_ctr.sv
module ehb_ident_ctr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] value
);

  logic [W-1:0] value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= INIT;
    else if (advance) value_q <= value_q + 1'b1;
  end

  assign value = value_q;

endmodule

// File: rtl/ehb_byte_tx.sv
module ehb_byte_tx #(
  parameter int unsigned BYTES = 36,
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BYTES*8-1:0] load_data,
  input  logic [CNT_W-1:0]   load_len,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_last,
  output logic               busy
);

  localparam int unsigned W = BYTES * 8;

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_data;
      cnt_q <= load_len;
    end else if (out_valid && out_ready) begin
      sh_q  <= sh_q << 8;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = sh_q[W-1 -: 8];
  assign out_last  = (cnt_q == CNT_W'(1));
  assign busy      = out_valid;

endmodule

// File: rtl/ehb_encap_top.sv
module ehb_encap_top
  import ehb_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 16,
  parameter int unsigned PORT_W     = 4,
  parameter int unsigned NUM_IFS    = 10,
  parameter logic [15:0] SUB_ETYPE  = 16'h88B5,
  parameter logic [7:0]  SUB_PROTO  = 8'hFD,
  parameter logic [7:0]  IP_TTL     = 8'd64,
  parameter logic [7:0]  IP_TOS     = 8'h00,
  parameter logic [15:0] FLAGS_FRAG = 16'h4000,
  parameter logic [15:0] IDENT_INIT = 16'h0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [3:0]                req_kind,
  input  logic [PORT_W-1:0]         req_port,
  input  logic [15:0]               req_link_id,
  input  logic [47:0]               req_dst_mac,
  input  logic [15:0]               req_tci,
  input  logic [31:0]               req_tun_dst,
  input  logic [47:0]               req_nh_mac,
  input  logic [15:0]               req_pay_len,
  input  logic [NUM_PORTS*48-1:0]   cfg_port_mac,
  input  logic [NUM_IFS*32-1:0]     cfg_if_ip,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [7:0]                out_data,
  output logic                      out_last
);

  localparam logic [LEN_W-1:0] LEN_ADD = LEN_W'(IP_HDR_BYTES + LID_BYTES);
  localparam int unsigned DIRECT_W = (ETH_BYTES + LID_BYTES) * 8;
  localparam int unsigned LEGACY_W = ETH_BYTES * 8;
  localparam int unsigned VLAN0_W  = (ETH_BYTES + 4 + LID_BYTES) * 8;

  logic                       accept;
  logic                       busy;
  shape_e                     shape;
  logic [MAC_W-1:0]           port_mac;
  logic [IP_W-1:0]            tun_src;
  logic [15:0]                ident_val;
  logic [LEN_W-1:0]           tot_len;
  logic [IP_HDR_BYTES*8-1:0]  ip_hdr;
  logic [HDR_W-1:0]           hdr_vec;
  logic [CNT_W-1:0]           hdr_len;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign shape     = kind_to_shape(req_kind);
  assign tot_len   = req_pay_len + LEN_ADD;

  ehb_port_table #(
    .ENTRY_W (MAC_W),
    .ENTRIES (NUM_PORTS),
    .IDX_W   (PORT_W)
  ) u_mac_tbl (
    .table_flat (cfg_port_mac),
    .idx        (req_port),
    .entry      (port_mac)
  );

  ehb_port_table #(
    .ENTRY_W (IP_W),
    .ENTRIES (NUM_IFS),
    .IDX_W   (PORT_W)
  ) u_ip_tbl (
    .table_flat (cfg_if_ip),
    .idx        (req_port),
    .entry      (tun_src)
  );

  ehb_ident_ctr #(
    .W    (16),
    .INIT (IDENT_INIT)
  ) u_ident (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept && (shape == SHP_TUNNEL)),
    .value   (ident_val)
  );

  ehb_ipv4_hdr #(
    .TOS        (IP_TOS),
    .TTL        (IP_TTL),
    .PROTO      (SUB_PROTO),
    .FLAGS_FRAG (FLAGS_FRAG)
  ) u_ip (
    .total_len (tot_len),
    .ident     (ident_val),
    .src_ip    (tun_src),
    .dst_ip    (req_tun_dst),
    .hdr       (ip_hdr)
  );

  // header image, byte 0 in the top bits
  always_comb begin
    hdr_vec = '0;
    hdr_len = shape_bytes(shape);
    case (shape)
      SHP_TUNNEL:
        hdr_vec = {req_dst_mac, port_mac, ETYPE_IPV4, ip_hdr, req_link_id};
      SHP_LEGACY:
        hdr_vec[HDR_W-1 -: LEGACY_W] = {req_nh_mac, port_mac, ETYPE_IPV4};
      SHP_VLAN0:
        hdr_vec[HDR_W-1 -: VLAN0_W] =
          {req_dst_mac, port_mac, ETYPE_VLAN, req_tci, SUB_ETYPE, req_link_id};
      SHP_MULTI:
        hdr_vec[HDR_W-1 -: DIRECT_W] = {req_nh_mac, port_mac, SUB_ETYPE, req_link_id};
      default:
        hdr_vec[HDR_W-1 -: DIRECT_W] = {req_dst_mac, port_mac, SUB_ETYPE, req_link_id};
    endcase
  end

  ehb_byte_tx #(
    .BYTES (MAX_HDR_BYTES),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (hdr_vec),
    .load_len  (hdr_len),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .busy      (busy)
  );

endmodule

// File: rtl/ehb_encap_chk.sv
module ehb_encap_chk
  import ehb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_kind,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [15:0] ident_q
);

  logic             take;
  logic             beat;
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] exp_q;

  assign take = req_valid && req_ready;
  assign beat = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      exp_q  <= '0;
    end else if (take) begin
      seen_q <= '0;
      exp_q  <= shape_bytes(kind_to_shape(req_kind));
    end else if (beat) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  p_busy_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_first_byte_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_tunnel_ident_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind_to_shape(req_kind) == SHP_TUNNEL) |=> (ident_q == 16'($past(ident_q) + 16'd1)));

  p_other_ident_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind_to_shape(req_kind) != SHP_TUNNEL) |=> $stable(ident_q));

  p_frame_len_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && out_last) |-> (CNT_W'(seen_q + 1'b1) == exp_q));

  p_last_with_valid_r14: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind ehb_encap_top ehb_encap_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .ident_q   (ident_val)
);

// File: tb/ehb_encap_top_tb_top.sv
module ehb_encap_top_tb_top;

  localparam int NP = 16;
  localparam int NI = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [3:0]      req_kind = '0;
  logic [3:0]      req_port = '0;
  logic [15:0]     req_link_id = '0;
  logic [47:0]     req_dst_mac = '0;
  logic [15:0]     req_tci = '0;
  logic [31:0]     req_tun_dst = '0;
  logic [47:0]     req_nh_mac = '0;
  logic [15:0]     req_pay_len = '0;
  logic [NP*48-1:0] cfg_port_mac;
  logic [NI*32-1:0] cfg_if_ip;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [7:0]      out_data;
  logic            out_last;

  int checks = 0;
  int failures = 0;
  bit stall_mode = 1'b0;
  logic [15:0] exp_ident = 16'hFFFE;

  logic [7:0] exp_data_q[$];
  bit         exp_last_q[$];
  string      exp_tag_q[$];

  always #10 clk = ~clk;

  ehb_encap_top #(.IDENT_INIT(16'hFFFE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_port(req_port), .req_link_id(req_link_id),
    .req_dst_mac(req_dst_mac), .req_tci(req_tci), .req_tun_dst(req_tun_dst),
    .req_nh_mac(req_nh_mac), .req_pay_len(req_pay_len),
    .cfg_port_mac(cfg_port_mac), .cfg_if_ip(cfg_if_ip),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [47:0] mac_of(int p);
    return {40'h02_00_5E_10_00, 8'(p * 3 + 1)};
  endfunction

  function automatic logic [31:0] ip_of(int p);
    if (p < NI) return {8'd10, 8'd1, 8'(p), 8'(p + 100)};
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic pb(input logic [7:0] b, input string tag);
    exp_data_q.push_back(b);
    exp_last_q.push_back(1'b0);
    exp_tag_q.push_back(tag);
  endtask

  task automatic p16(input logic [15:0] v, input string tag);
    pb(v[15:8], tag);
    pb(v[7:0], tag);
  endtask

  task automatic p48(input logic [47:0] v, input string tag);
    p16(v[47:32], tag);
    p16(v[31:16], tag);
    p16(v[15:0], tag);
  endtask

  task automatic send(input logic [3:0] kind, input logic [3:0] port, input logic [15:0] lid,
                      input logic [47:0] dmac, input logic [47:0] nhmac, input logic [15:0] tci,
                      input logic [15:0] plen, input logic [31:0] tdst, input string tag);
    logic [15:0] iw [10];
    int unsigned s;
    // expected bytes, derived from R4 R5 R6 R7 R8 R9 R10 R11 R12 R13
    p48((kind == 4'd2 || kind == 4'd4) ? nhmac : dmac, tag);
    p48(mac_of(int'(port)), tag);
    case (kind)
      4'd1: begin
        p16(16'h0800, tag);
        iw[0] = 16'h4500; iw[1] = 16'(plen + 16'd22); iw[2] = exp_ident; iw[3] = 16'h4000;
        iw[4] = 16'h40FD; iw[5] = 16'h0000;
        iw[6] = ip_of(int'(port)) >> 16; iw[7] = ip_of(int'(port)) & 32'hFFFF;
        iw[8] = tdst[31:16]; iw[9] = tdst[15:0];
        s = 0;
        for (int i = 0; i < 10; i++) s += 32'(iw[i]);
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        iw[5] = ~16'(s);
        for (int i = 0; i < 10; i++) p16(iw[i], tag);
        p16(lid, tag);
        exp_ident = exp_ident + 16'd1;
      end
      4'd2: p16(16'h0800, tag);
      4'd3: begin
        p16(16'h8100, tag); p16(tci, tag); p16(16'h88B5, tag); p16(lid, tag);
      end
      default: begin
        p16(16'h88B5, tag); p16(lid, tag);
      end
    endcase
    exp_last_q[exp_last_q.size() - 1] = 1'b1;

    req_kind = kind; req_port = port; req_link_id = lid; req_dst_mac = dmac;
    req_nh_mac = nhmac; req_tci = tci; req_pay_len = plen; req_tun_dst = tdst;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    // R2: first byte next cycle, no further request taken
    check(out_valid === 1'b1 && req_ready === 1'b0, "R2 accept", {out_valid, req_ready}, 2'b10);
    @(posedge clk); #2;
  endtask

  // back-pressure generator
  initial begin : ready_gen
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  // scoreboard monitor
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic       prev_last;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid === 1'b1 && out_data === prev_data && out_last === prev_last, "R3 stall hold",
              {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
      if (out_valid && out_ready) begin
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R2 unexpected byte", 64'(out_data), 64'd0);
        end else begin
          logic [7:0] d;
          bit l;
          string t;
          d = exp_data_q.pop_front();
          l = exp_last_q.pop_front();
          t = exp_tag_q.pop_front();
          check(out_data === d, t, 64'(out_data), 64'(d));
          check(out_last === l, "R14 last flag", 64'(out_last), 64'(l));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    check(1'b0, "WATCHDOG expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin : main
    for (int p = 0; p < NP; p++) cfg_port_mac[p*48 +: 48] = mac_of(p);
    for (int i = 0; i < NI; i++) cfg_if_ip[i*32 +: 32] = ip_of(i);
    @(negedge clk);
    check(out_valid === 1'b0 && req_ready === 1'b1, "R1 during reset", {out_valid, req_ready}, 2'b01);
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && req_ready === 1'b1, "R1 after reset", {out_valid, req_ready}, 2'b01);
    @(posedge clk); #2;

    // free-running consumer
    send(4'd0, 4'd3, 16'h1234, 48'hAABB_CCDD_EE01, 48'h1111_2222_3333, 16'h0, 16'd100, 32'h0, "R4/R10 direct");
    send(4'd1, 4'd2, 16'h0BCD, 48'h0A0B_0C0D_0E0F, 48'h1111_2222_3333, 16'h0, 16'd64, 32'hC0A8_0101, "R5/R6/R7/R8/R9 tunnel");
    send(4'd2, 4'd5, 16'h7777, 48'hDEAD_BEEF_0001, 48'h0011_2233_4455, 16'h0, 16'd40, 32'h0, "R11 legacy");
    send(4'd3, 4'd15, 16'h00FE, 48'h5566_7788_99AA, 48'h1111_2222_3333, 16'hA00B, 16'd0, 32'h0, "R12/R10 vlan0");
    send(4'd4, 4'd0, 16'hFFFF, 48'hDEAD_BEEF_0002, 48'h6677_8899_AABB, 16'h0, 16'd9, 32'h0, "R11 multi-access");
    send(4'd1, 4'd12, 16'h4242, 48'h0102_0304_0506, 48'h0, 16'h0, 16'hFFF0, 32'h0808_0404, "R9/R6 tunnel port>=10 len wrap");
    send(4'd9, 4'd7, 16'h5A5A, 48'hCAFE_0000_0009, 48'h1111_2222_3333, 16'h0, 16'd1, 32'h0, "R13 code 9");

    // random back-pressure
    stall_mode = 1'b1;
    send(4'd1, 4'd9, 16'h0001, 48'h7000_0000_0001, 48'h0, 16'h0, 16'd1500, 32'hFFFF_FFFF, "R8/R7 tunnel ident wrap");
    send(4'd3, 4'd1, 16'h0202, 48'h7000_0000_0002, 48'h0, 16'hFFFF, 16'd0, 32'h0, "R12 vlan0 stalled");
    send(4'd4, 4'd14, 16'h0303, 48'h7000_0000_0003, 48'h0E0E_0E0E_0E0E, 16'h0, 16'd0, 32'h0, "R11 multi stalled");
    send(4'd1, 4'd0, 16'h0404, 48'h7000_0000_0004, 48'h0, 16'h0, 16'd0, 32'h0000_0000, "R5/R8 tunnel after wrap");
    send(4'd15, 4'd6, 16'h0505, 48'h7000_0000_0005, 48'h0, 16'h0, 16'd0, 32'h0, "R13 code 15");

    while (exp_data_q.size() != 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && req_ready === 1'b1, "R2 idle after drain", {out_valid, req_ready}, 2'b01);
    summary();
    $finish;
  end

endmodule